// File: doc/BRIEF.md
# Floating-Point NaN Propagation Unit

This unit sits beside the arithmetic datapath of a floating-point add, subtract, multiply or divide stage. It decides what the result must be when either source operand is a NaN or when the operation has no defined numerical answer. For any other operand pair it lets the datapath's own result pass through. It handles single precision and double precision words. A format input picks the precision, and in single precision only the low 32 bits of each operand bus are looked at.

The first operand always has priority when both operands are NaNs. A signaling NaN is turned into a quiet one by setting the top fraction bit and keeping every other bit. If neither operand is a NaN but the operation is undefined, the unit produces the default quiet NaN. An invalid condition that is not masked withholds the result: the unit raises only the exception flag. Outputs are registered once by default, and a parameter can remove that register stage.

Top module: `fp_nan_resolver`

## Requirements
- R1: An operand is a NaN when its exponent is all ones and its fraction is nonzero. In single precision the unit examines only bits 31:0 of each operand, and a NaN-derived result has bits 63:32 cleared. An all-ones exponent with a zero fraction is an infinity, not a NaN.
- R2: When the first operand is a NaN, the result is the first operand made quiet, whatever the second operand is.
- R3: When only the second operand is a NaN, the result is the second operand made quiet.
- R4: Quieting sets bit 22 (single) or bit 51 (double) and keeps the sign, exponent and payload bits unchanged. A quiet NaN input therefore comes out unchanged.
- R5: Invalid is raised whenever either operand is a signaling NaN (top fraction bit 0), including a quiet first NaN paired with a signaling second NaN.
- R6: Operations whose NaN operands are all quiet (top fraction bit 1) raise no invalid.
- R7: Operation code 2'b00 is add and 2'b01 is subtract. Infinity plus infinity of opposite signs, or infinity minus infinity of equal signs, is invalid and gives the default quiet NaN. The other sign combinations pass the arithmetic result through.
- R8: Operation code 2'b10 is multiply and 2'b11 is divide. Infinity times zero (either order), infinity over infinity and zero over zero are invalid. They give the default quiet NaN: 0xFFC00000 in single precision, 0xFFF8000000000000 in double precision.
- R9: With `inv_mask` low, an invalid case drives `res_valid` and `res_override` low, `res_word` to zero and `res_invalid` high. Whenever `res_valid` is low, `res_word` is zero and `res_override` is low.
- R10: With no NaN and no invalid operation, `res_override` is low and `res_word` equals `arith_res` (all 64 bits). With `in_valid` low, all outputs are zero.
- R11: With the default register stage, outputs appear one clock after the inputs and are all zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and arithmetic result are present |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision |
| op_code | input | 2 | 00 add, 01 subtract, 10 multiply, 11 divide |
| opnd_a | input | 64 | First source operand |
| opnd_b | input | 64 | Second source operand |
| inv_mask | input | 1 | 1 = invalid exception masked |
| arith_res | input | 64 | Result from the arithmetic datapath |
| res_valid | output | 1 | A result is delivered |
| res_override | output | 1 | Use `res_word` instead of the arithmetic result |
| res_invalid | output | 1 | Invalid exception raised |
| res_word | output | 64 | Delivered result word |

## Verification
NaN selection and invalid signalling land in the same cycle when a quiet first NaN meets a signaling second NaN. In that case the result must come from the first operand while the invalid flag comes from the second. The bench drives this pair, and also signaling-with-quiet pairs, with the mask set. It checks the result word and the invalid flag of that single output cycle together. It then repeats NaN and undefined-operation cases with the mask cleared, where suppression must override the selection: valid and override low, word zero, invalid high.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;
    localparam int WORD_W    = 64;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRC_W  = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRC_W  = 52;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRC_W;
    localparam int DP_W      = 1 + DP_EXP_W + DP_FRC_W;
    localparam int SP_QBIT   = SP_FRC_W - 1;
    localparam int DP_QBIT   = DP_FRC_W - 1;

    localparam logic [SP_W-1:0] SP_DEF_QNAN = 32'hFFC0_0000;
    localparam logic [DP_W-1:0] DP_DEF_QNAN = 64'hFFF8_0000_0000_0000;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } fp_op_e;

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } fp_cls_t;

    typedef struct packed {
        logic              valid;
        logic              override;
        logic              invalid;
        logic [WORD_W-1:0] res;
    } fp_out_t;
endpackage

// File: rtl/fp_opnd_class.sv
module fp_opnd_class
    import fp_nan_pkg::*;
(
    input  logic              fmt_dbl,
    input  logic [WORD_W-1:0] word,
    output fp_cls_t           cls
);
    logic [SP_EXP_W-1:0] sp_exp;
    logic [SP_FRC_W-1:0] sp_frc;
    logic [DP_EXP_W-1:0] dp_exp;
    logic [DP_FRC_W-1:0] dp_frc;
    logic                exp_ones;
    logic                exp_zero;
    logic                frc_nz;
    logic                qbit;

    assign sp_exp = word[SP_W-2 -: SP_EXP_W];
    assign sp_frc = word[SP_FRC_W-1:0];
    assign dp_exp = word[DP_W-2 -: DP_EXP_W];
    assign dp_frc = word[DP_FRC_W-1:0];

    always_comb begin
        if (fmt_dbl) begin
            exp_ones = &dp_exp;
            exp_zero = ~|dp_exp;
            frc_nz   = |dp_frc;
            qbit     = dp_frc[DP_QBIT];
            cls.sign = word[DP_W-1];
        end else begin
            exp_ones = &sp_exp;
            exp_zero = ~|sp_exp;
            frc_nz   = |sp_frc;
            qbit     = sp_frc[SP_QBIT];
            cls.sign = word[SP_W-1];
        end
        cls.is_nan  = exp_ones & frc_nz;
        cls.is_snan = exp_ones & frc_nz & ~qbit;
        cls.is_inf  = exp_ones & ~frc_nz;
        cls.is_zero = exp_zero & ~frc_nz;
    end
endmodule

// File: rtl/fp_inval_detect.sv
module fp_inval_detect
    import fp_nan_pkg::*;
(
    input  fp_op_e  op,
    input  fp_cls_t ca,
    input  fp_cls_t cb,
    output logic    op_inv
);
    logic both_inf;
    logic both_zero;
    logic sign_diff;

    assign both_inf  = ca.is_inf & cb.is_inf;
    assign both_zero = ca.is_zero & cb.is_zero;
    assign sign_diff = ca.sign ^ cb.sign;

    always_comb begin
        unique case (op)
            OP_ADD:  op_inv = both_inf & sign_diff;
            OP_SUB:  op_inv = both_inf & ~sign_diff;
            OP_MUL:  op_inv = (ca.is_inf & cb.is_zero) | (ca.is_zero & cb.is_inf);
            OP_DIV:  op_inv = both_inf | both_zero;
            default: op_inv = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_nan_pick.sv
module fp_nan_pick
    import fp_nan_pkg::*;
(
    input  logic              fmt_dbl,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  fp_cls_t           ca,
    input  fp_cls_t           cb,
    input  logic              op_inv,
    output logic              hit,
    output logic [WORD_W-1:0] nan_res
);
    function automatic logic [WORD_W-1:0] make_quiet(input logic dbl,
                                                     input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] q;
        if (dbl) begin
            q          = w;
            q[DP_QBIT] = 1'b1;
        end else begin
            q             = '0;
            q[SP_W-1:0]   = w[SP_W-1:0];
            q[SP_QBIT]    = 1'b1;
        end
        return q;
    endfunction

    always_comb begin
        hit     = 1'b0;
        nan_res = '0;
        if (ca.is_nan) begin
            hit     = 1'b1;
            nan_res = make_quiet(fmt_dbl, word_a);
        end else if (cb.is_nan) begin
            hit     = 1'b1;
            nan_res = make_quiet(fmt_dbl, word_b);
        end else if (op_inv) begin
            hit     = 1'b1;
            nan_res = fmt_dbl ? WORD_W'(DP_DEF_QNAN) : WORD_W'(SP_DEF_QNAN);
        end
    end
endmodule

// File: rtl/fp_nan_resolver.sv
module fp_nan_resolver
    import fp_nan_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              fmt_dbl,
    input  logic [1:0]        op_code,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic              inv_mask,
    input  logic [WORD_W-1:0] arith_res,
    output logic              res_valid,
    output logic              res_override,
    output logic              res_invalid,
    output logic [WORD_W-1:0] res_word
);
    fp_cls_t           cls_a;
    fp_cls_t           cls_b;
    logic              op_inv;
    logic              pick_hit;
    logic [WORD_W-1:0] pick_res;
    logic              any_inv;
    fp_out_t           out_d;
    fp_out_t           out_q;

    fp_opnd_class u_cls_a (.fmt_dbl(fmt_dbl), .word(opnd_a), .cls(cls_a));
    fp_opnd_class u_cls_b (.fmt_dbl(fmt_dbl), .word(opnd_b), .cls(cls_b));

    fp_inval_detect u_inv (
        .op    (fp_op_e'(op_code)),
        .ca    (cls_a),
        .cb    (cls_b),
        .op_inv(op_inv)
    );

    fp_nan_pick u_pick (
        .fmt_dbl(fmt_dbl),
        .word_a (opnd_a),
        .word_b (opnd_b),
        .ca     (cls_a),
        .cb     (cls_b),
        .op_inv (op_inv),
        .hit    (pick_hit),
        .nan_res(pick_res)
    );

    assign any_inv = cls_a.is_snan | cls_b.is_snan | op_inv;

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.invalid = any_inv;
            if (!(any_inv && !inv_mask)) begin
                out_d.valid    = 1'b1;
                out_d.override = pick_hit;
                out_d.res      = pick_hit ? pick_res : arith_res;
            end
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign res_valid    = out_q.valid;
    assign res_override = out_q.override;
    assign res_invalid  = out_q.invalid;
    assign res_word     = out_q.res;
endmodule

// File: rtl/fp_nan_resolver_chk.sv
module fp_nan_resolver_chk
    import fp_nan_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              fmt_dbl,
    input logic              inv_mask,
    input logic [WORD_W-1:0] arith_res,
    input logic              res_valid,
    input logic              res_override,
    input logic              res_invalid,
    input logic [WORD_W-1:0] res_word
);
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_override && res_word == '0));

    generate
        if (OUT_REG) begin : g_seq
            // R9
            unmasked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_invalid && !$past(inv_mask)) |-> !res_valid);
            // R4
            override_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                res_override |-> ($past(fmt_dbl) ? res_word[DP_QBIT] : res_word[SP_QBIT]));
            // R1
            sp_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_override && !$past(fmt_dbl)) |-> (res_word[WORD_W-1:SP_W] == '0));
            // R10
            pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && !res_override) |-> (res_word == $past(arith_res)));
            // R11
            latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid || res_invalid) |-> $past(in_valid));
        end
    endgenerate
endmodule

bind fp_nan_resolver fp_nan_resolver_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .fmt_dbl     (fmt_dbl),
    .inv_mask    (inv_mask),
    .arith_res   (arith_res),
    .res_valid   (res_valid),
    .res_override(res_override),
    .res_invalid (res_invalid),
    .res_word    (res_word)
);

// File: tb/fp_nan_resolver_tb.sv
module fp_nan_resolver_tb;
    typedef struct packed {
        logic        v;
        logic        o;
        logic        i;
        logic [63:0] r;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        inv_mask = 1'b1;
    logic [63:0] arith_res = '0;
    logic        res_valid;
    logic        res_override;
    logic        res_invalid;
    logic [63:0] res_word;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    fp_nan_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
        .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .inv_mask(inv_mask),
        .arith_res(arith_res), .res_valid(res_valid), .res_override(res_override),
        .res_invalid(res_invalid), .res_word(res_word)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic drive(input logic dbl, input logic [1:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic msk, input logic [63:0] ar,
                         input logic ev, input logic eo, input logic ei,
                         input logic [63:0] er, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; fmt_dbl = dbl; op_code = op;
        opnd_a = a; opnd_b = b; inv_mask = msk; arith_res = ar;
        e.v = ev; e.o = eo; e.i = ei; e.r = er;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        opnd_a = 64'h7FF0_0000_0000_0001; opnd_b = '0; arith_res = 64'hDEAD_BEEF;
        e = '0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expected item per cycle after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(res_valid    == e.v, t, "valid",    64'(res_valid),    64'(e.v));
                check(res_override == e.o, t, "override", 64'(res_override), 64'(e.o));
                check(res_invalid  == e.i, t, "invalid",  64'(res_invalid),  64'(e.i));
                check(res_word     == e.r, t, "word",     res_word,          e.r);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [63:0] ONE_S  = 64'h3F80_0000;
    localparam logic [63:0] INF_S  = 64'h7F80_0000;
    localparam logic [63:0] NINF_S = 64'hFF80_0000;
    localparam logic [63:0] ZRO    = 64'h0;
    localparam logic [63:0] DEF_S  = 64'hFFC0_0000;
    localparam logic [63:0] DEF_D  = 64'hFFF8_0000_0000_0000;
    localparam logic [63:0] AR     = 64'h1234_5678_4000_0000;

    initial begin
        // R11 reset state
        #25;
        check(res_valid == 0 && res_override == 0 && res_invalid == 0 && res_word == 0,
              "R11", "reset", res_word, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: sNaN a, sNaN b, masked
        drive(0, 2'b00, 64'hFFA1_2345, 64'h7F80_0001, 1, AR, 1, 1, 1, 64'hFFE1_2345, "R2");
        // R2: sNaN a, qNaN b
        drive(0, 2'b10, 64'hFFA1_2345, 64'h7FC0_0005, 1, AR, 1, 1, 1, 64'hFFE1_2345, "R2");
        // R5: qNaN a, sNaN b -> a unchanged, invalid
        drive(0, 2'b01, 64'h7FC0_0005, 64'h7F80_0001, 1, AR, 1, 1, 1, 64'h7FC0_0005, "R5");
        // R6: qNaN a, qNaN b
        drive(0, 2'b11, 64'h7FC0_0005, 64'hFFC0_0777, 1, AR, 1, 1, 0, 64'h7FC0_0005, "R6");
        // R3: real a, sNaN b
        drive(0, 2'b00, ONE_S, 64'h7F80_0001, 1, AR, 1, 1, 1, 64'h7FC0_0001, "R3");
        // R3: real a, qNaN b
        drive(0, 2'b10, ONE_S, 64'hFFC0_0777, 1, AR, 1, 1, 0, 64'hFFC0_0777, "R3");
        // R4: double sNaN a quieted, payload and sign kept
        drive(1, 2'b00, 64'hFFF0_0000_0000_0ABC, 64'h3FF0_0000_0000_0000, 1, AR,
              1, 1, 1, 64'hFFF8_0000_0000_0ABC, "R4");
        // R4: double qNaN b passed unchanged
        drive(1, 2'b11, 64'h3FF0_0000_0000_0000, 64'h7FFC_0000_0000_1234, 1, AR,
              1, 1, 0, 64'h7FFC_0000_0000_1234, "R4");
        // R1: single mode ignores upper bits, NaN result upper bits cleared
        drive(0, 2'b00, 64'h1234_5678_3F80_0000, 64'hFFFF_FFFF_7FC0_0001, 1, AR,
              1, 1, 0, 64'h0000_0000_7FC0_0001, "R1");
        // R1: upper bits all ones in single mode but low word is 1.0 -> no NaN
        drive(0, 2'b10, 64'hFFFF_FFFF_3F80_0000, 64'h7FF0_0000_3F80_0000, 1, AR,
              1, 0, 0, AR, "R1");
        // R1: infinity is not NaN
        drive(0, 2'b10, INF_S, ONE_S, 1, AR, 1, 0, 0, AR, "R1");
        // R7: add and subtract infinities
        drive(0, 2'b00, INF_S, NINF_S, 1, AR, 1, 1, 1, DEF_S, "R7");
        drive(0, 2'b00, INF_S, INF_S, 1, AR, 1, 0, 0, AR, "R7");
        drive(0, 2'b01, NINF_S, NINF_S, 1, AR, 1, 1, 1, DEF_S, "R7");
        drive(0, 2'b01, INF_S, NINF_S, 1, AR, 1, 0, 0, AR, "R7");
        // R8: multiply and divide invalid cases
        drive(0, 2'b10, INF_S, ZRO, 1, AR, 1, 1, 1, DEF_S, "R8");
        drive(0, 2'b10, 64'h8000_0000, NINF_S, 1, AR, 1, 1, 1, DEF_S, "R8");
        drive(0, 2'b11, INF_S, NINF_S, 1, AR, 1, 1, 1, DEF_S, "R8");
        drive(0, 2'b11, ZRO, ZRO, 1, AR, 1, 1, 1, DEF_S, "R8");
        drive(0, 2'b11, ONE_S, ZRO, 1, AR, 1, 0, 0, AR, "R8");
        drive(1, 2'b11, ZRO, 64'h8000_0000_0000_0000, 1, AR, 1, 1, 1, DEF_D, "R8");
        drive(1, 2'b10, 64'h7FF0_0000_0000_0000, ZRO, 1, AR, 1, 1, 1, DEF_D, "R8");
        // R9: unmasked invalid suppresses result
        drive(0, 2'b00, 64'h7F80_0001, ONE_S, 0, AR, 0, 0, 1, 64'h0, "R9");
        drive(0, 2'b01, 64'h7FC0_0005, 64'h7F80_0001, 0, AR, 0, 0, 1, 64'h0, "R9");
        drive(1, 2'b11, ZRO, ZRO, 0, AR, 0, 0, 1, 64'h0, "R9");
        // R9: unmasked but only quiet NaNs -> delivered normally
        drive(0, 2'b10, 64'h7FC0_0005, ONE_S, 0, AR, 1, 1, 0, 64'h7FC0_0005, "R9");
        // R10: ordinary operands pass the arithmetic result
        drive(0, 2'b00, ONE_S, ONE_S, 0, AR, 1, 0, 0, AR, "R10");
        drive(1, 2'b10, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1,
              64'hCAFE_F00D_1234_5678, 1, 0, 0, 64'hCAFE_F00D_1234_5678, "R10");
        idle("R10");
        // R11: back-to-back results each appear one cycle later
        drive(0, 2'b00, INF_S, NINF_S, 1, AR, 1, 1, 1, DEF_S, "R11");
        drive(0, 2'b00, ONE_S, ONE_S, 1, AR, 1, 0, 0, AR, "R11");
        idle("R11");
        idle("R11");

        repeat (5) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R11 pending results actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule